// File: doc/BRIEF.md
# Miss-Gated Prefetch Trigger

This block sits beside an L1 data cache and decides, for each demand access, whether a downstream address generator should start a prefetch. Every cycle it examines a fixed number of demand request slots (four by default). Each slot carries a byte address, a cache hit flag, a flag saying the line was brought in by a prefetch, and a strobe marking the request as new this cycle. A slot is a trigger candidate only if it is new and is either a miss or a hit on a prefetched line.

The block keeps a small table of outstanding line misses. A demand miss to a line that is not in the table allocates an entry. A hit on a prefetched line only looks the line up and never allocates. A candidate whose line is found in the table is suppressed. Entries retire a fixed number of cycles after allocation. Retirement uses a free-running cycle counter and takes effect before the requests of that cycle are looked at. Slots are handled in ascending order, so a slot sees the entries allocated by lower slots in the same cycle. The trigger vector is registered and appears one cycle after the request.

Top module: `pft_trigger_gate`

## Requirements
- R1: After reset the trigger vector is all zero and the miss table is empty, so the first miss to any line triggers.
- R2: A slot whose strobe is low never triggers. A slot that is a hit on a line whose prefetched flag is 0 never triggers.
- R3: Lines are compared on address bits [ADDR_W-1:6]. Two addresses that differ only in bits [5:0] refer to the same line.
- R4: A new miss whose line is absent from the table triggers and allocates an entry. A later miss to that line, while the entry is live, is suppressed.
- R5: A hit on a prefetched line whose line is absent triggers but allocates nothing, so a following miss to that line still triggers.
- R6: A hit on a prefetched line whose line is held by a live entry does not trigger.
- R7: An entry allocated in cycle t suppresses matching requests in cycles t+1 to t+LATENCY-1. From cycle t+LATENCY on, it no longer matches.
- R8: When every entry is live, an eligible miss to an absent line still triggers but is not recorded, so a repeat of that miss triggers again.
- R9: Slots are evaluated in order 0 upward. A slot sees the allocations made by lower-numbered slots in the same cycle.
- R10: The trigger for a request presented in cycle t appears on `trig` in cycle t+1 only, as one bit per slot (bit s for slot s).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NS | Per-slot strobe: the request is new this cycle |
| req_hit | input | NS | Per-slot cache hit flag (1 = hit) |
| req_pf | input | NS | Per-slot flag: the hit line was filled by a prefetch |
| req_addr | input | NS x ADDR_W | Per-slot byte address |
| trig | output | NS | Per-slot registered prefetch trigger pulse |

## Verification
The bench builds the block with a four-entry table and a retirement latency of 12 cycles, and keeps the four slots and 32-bit addresses. The shallow table can be filled by a single cycle of four distinct misses, which makes the untracked-miss behaviour of a full table reachable. The short latency lets a few idle cycles flush the table. It also lets the bench probe the cycles just before and exactly at retirement. A reference model in the bench ages its own entries by remaining lifetime rather than by comparing against a counter.

// File: rtl/pft_pkg.sv
package pft_pkg;

  // Line number of a byte address: drop the in-line offset bits.
  function automatic logic [63:0] line_of(input logic [63:0] addr, input int ofs);
    return addr >> ofs;
  endfunction

  // Expiry stamp for an entry allocated at counter value now.
  function automatic logic [31:0] expiry_of(input logic [31:0] now, input int lat);
    return now + 32'(lat);
  endfunction

endpackage

// File: rtl/pft_cycle_ctr.sv
module pft_cycle_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cyc
);
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1'b1;
  end
endmodule

// File: rtl/pft_mshr_store.sv
module pft_mshr_store
  import pft_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 26,
  parameter int CNT_W   = 16,
  parameter int LATENCY = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cyc,
  input  logic [DEPTH-1:0]     nxt_vld,
  input  logic [DEPTH-1:0]     set_mask,
  input  logic [TAG_W-1:0]     set_tag  [DEPTH],
  output logic [DEPTH-1:0]     live_vld,
  output logic [DEPTH-1:0]     release_mask,
  output logic [TAG_W-1:0]     ent_tag  [DEPTH]
);
  logic [DEPTH-1:0] vld;
  logic [CNT_W-1:0] ent_exp [DEPTH];
  logic [CNT_W-1:0] new_exp;

  assign new_exp = CNT_W'(expiry_of(32'(cyc), LATENCY));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign release_mask[i] = vld[i] && (ent_exp[i] == cyc);
    assign live_vld[i]     = vld[i] && !release_mask[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i]     <= 1'b0;
        ent_tag[i] <= '0;
        ent_exp[i] <= '0;
      end else begin
        vld[i] <= nxt_vld[i];
        if (set_mask[i]) begin
          ent_tag[i] <= set_tag[i];
          ent_exp[i] <= new_exp;
        end
      end
    end
  end
endmodule

// File: rtl/pft_slot_chain.sv
module pft_slot_chain
  import pft_pkg::*;
#(
  parameter int NS       = 4,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int DEPTH    = 16,
  parameter int TAG_W    = ADDR_W - LINE_OFS
) (
  input  logic [NS-1:0]             req_valid,
  input  logic [NS-1:0]             req_hit,
  input  logic [NS-1:0]             req_pf,
  input  logic [NS-1:0][ADDR_W-1:0] req_addr,
  input  logic [DEPTH-1:0]          live_vld,
  input  logic [TAG_W-1:0]          ent_tag   [DEPTH],
  output logic [DEPTH-1:0]          nxt_vld,
  output logic [DEPTH-1:0]          set_mask,
  output logic [TAG_W-1:0]          set_tag   [DEPTH],
  output logic [NS-1:0]             slot_elig,
  output logic [NS-1:0]             slot_match,
  output logic [NS-1:0]             slot_alloc,
  output logic [NS-1:0]             trig_c
);
  logic [TAG_W-1:0] slot_tag [NS];

  for (genvar s = 0; s < NS; s++) begin : g_tag
    assign slot_tag[s] = TAG_W'(line_of(64'(req_addr[s]), LINE_OFS));
  end

  logic [DEPTH-1:0] work_v;
  logic [TAG_W-1:0] work_t [DEPTH];
  logic             m;
  logic             placed;

  always_comb begin
    work_v     = live_vld;
    work_t     = ent_tag;
    set_mask   = '0;
    slot_elig  = '0;
    slot_match = '0;
    slot_alloc = '0;
    trig_c     = '0;
    m          = 1'b0;
    placed     = 1'b0;
    for (int s = 0; s < NS; s++) begin
      slot_elig[s] = req_valid[s] & (~req_hit[s] | req_pf[s]);
      m = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (work_v[i] && (work_t[i] == slot_tag[s])) m = 1'b1;
      end
      slot_match[s] = slot_elig[s] & m;
      trig_c[s]     = slot_elig[s] & ~m;
      placed = 1'b0;
      if (slot_elig[s] && !req_hit[s] && !m) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!placed && !work_v[i]) begin
            work_v[i]   = 1'b1;
            work_t[i]   = slot_tag[s];
            set_mask[i] = 1'b1;
            placed      = 1'b1;
          end
        end
      end
      slot_alloc[s] = placed;
    end
  end

  assign nxt_vld = work_v;
  assign set_tag = work_t;
endmodule

// File: rtl/pft_trigger_gate.sv
module pft_trigger_gate #(
  parameter int NS       = 4,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int DEPTH    = 16,
  parameter int LATENCY  = 200,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NS-1:0]             req_valid,
  input  logic [NS-1:0]             req_hit,
  input  logic [NS-1:0]             req_pf,
  input  logic [NS-1:0][ADDR_W-1:0] req_addr,
  output logic [NS-1:0]             trig
);
  localparam int TAG_W = ADDR_W - LINE_OFS;

  logic [CNT_W-1:0] cyc;
  logic [DEPTH-1:0] live_vld, release_mask, nxt_vld, set_mask;
  logic [TAG_W-1:0] ent_tag [DEPTH];
  logic [TAG_W-1:0] set_tag [DEPTH];
  logic [NS-1:0]    slot_elig, slot_match, slot_alloc, trig_c;
  logic             table_full;

  assign table_full = &live_vld;

  pft_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (.clk(clk), .rst_n(rst_n), .cyc(cyc));

  pft_mshr_store #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .LATENCY(LATENCY)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cyc(cyc),
    .nxt_vld(nxt_vld), .set_mask(set_mask), .set_tag(set_tag),
    .live_vld(live_vld), .release_mask(release_mask), .ent_tag(ent_tag)
  );

  pft_slot_chain #(
    .NS(NS), .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .DEPTH(DEPTH), .TAG_W(TAG_W)
  ) u_chain (
    .req_valid(req_valid), .req_hit(req_hit), .req_pf(req_pf), .req_addr(req_addr),
    .live_vld(live_vld), .ent_tag(ent_tag),
    .nxt_vld(nxt_vld), .set_mask(set_mask), .set_tag(set_tag),
    .slot_elig(slot_elig), .slot_match(slot_match), .slot_alloc(slot_alloc),
    .trig_c(trig_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= '0;
    else        trig <= trig_c;
  end
endmodule

// File: rtl/pft_trigger_gate_chk.sv
module pft_trigger_gate_chk #(
  parameter int NS    = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NS-1:0]    req_valid,
  input logic [NS-1:0]    req_hit,
  input logic [NS-1:0]    req_pf,
  input logic [NS-1:0]    trig,
  input logic [NS-1:0]    slot_elig,
  input logic [NS-1:0]    slot_match,
  input logic [NS-1:0]    slot_alloc,
  input logic             table_full,
  input logic [CNT_W-1:0] cyc
);
  // R2
  trig_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |-> ((trig & ~$past(req_valid & (~req_hit | req_pf))) == '0));

  // R5
  hit_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_alloc & (req_hit | ~req_valid)) == '0));

  // R8
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_full |-> (slot_alloc == '0));

  // R6
  match_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_elig & slot_match) != '0) |=> ((trig & $past(slot_elig & slot_match)) == '0));

  // R7
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cyc == CNT_W'($past(cyc) + 1'b1)));
endmodule

bind pft_trigger_gate pft_trigger_gate_chk #(.NS(NS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
  .req_pf(req_pf), .trig(trig), .slot_elig(slot_elig), .slot_match(slot_match),
  .slot_alloc(slot_alloc), .table_full(table_full), .cyc(cyc)
);

// File: tb/pft_trigger_gate_test.sv
module pft_trigger_gate_test;
  localparam int NS = 4, AW = 32, OFS = 6, DEPTH = 4, LAT = 12, CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] req_valid = '0, req_hit = '0, req_pf = '0;
  logic [NS-1:0][AW-1:0] req_addr = '0;
  logic [NS-1:0] trig;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pft_trigger_gate #(.NS(NS), .ADDR_W(AW), .LINE_OFS(OFS), .DEPTH(DEPTH),
                     .LATENCY(LAT), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_pf(req_pf), .req_addr(req_addr), .trig(trig));

  // reference model: lines and remaining lifetimes
  logic [AW-1:0] m_line [DEPTH];
  int            m_rem  [DEPTH];
  bit            m_used [DEPTH];

  logic [NS-1:0] exp_q [$];
  string         tag_q [$];

  task automatic model_step(input logic [NS-1:0] v, h, p,
                            input logic [NS-1:0][AW-1:0] a,
                            output logic [NS-1:0] e);
    e = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_used[i]) begin
        m_rem[i] = m_rem[i] - 1;
        if (m_rem[i] <= 0) m_used[i] = 0;
      end
    for (int s = 0; s < NS; s++) begin
      bit found = 0;
      logic [AW-1:0] ln = a[s] / 64;
      if (!(v[s] && (!h[s] || p[s]))) continue;
      for (int i = 0; i < DEPTH; i++)
        if (m_used[i] && m_line[i] == ln) found = 1;
      if (found) continue;
      e[s] = 1'b1;
      if (!h[s]) begin
        for (int i = DEPTH - 1; i >= 0; i--)
          if (!m_used[i] && !found) begin
            m_used[i] = 1; m_line[i] = ln; m_rem[i] = LAT; found = 1;
          end
      end
    end
  endtask

  task automatic issue(input logic [NS-1:0] v, h, p,
                       input logic [NS-1:0][AW-1:0] a, input string rq);
    logic [NS-1:0] e;
    @(negedge clk);
    req_valid = v; req_hit = h; req_pf = p; req_addr = a;
    model_step(v, h, p, a, e);
    exp_q.push_back(e);
    tag_q.push_back(rq);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) issue('0, '0, '0, '0, "R2");
  endtask

  // monitor: compare one item per clock edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [NS-1:0] e;
      string rq;
      e = exp_q.pop_front();
      rq = tag_q.pop_front();
      checks++;
      if (trig !== e) begin
        errors++;
        $display("FAIL %s (R10 timing): trig=%b expected=%b", rq, trig, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [AW-1:0] LA = 32'h0000_1000, LB = 32'h0000_2040,
                            LC = 32'h0003_0000, LD = 32'h0004_0080,
                            LE = 32'h0005_0000;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_used[i] = 0; m_rem[i] = 0; m_line[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    // R1: reset state
    if (trig !== '0) begin
      errors++;
      $display("FAIL R1: trig=%b expected=0000", trig);
    end
    // R1/R10: first miss triggers, next cycle
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LA}, "R1");
    // R2: plain hit, and a miss with strobe low
    issue(4'b0001, 4'b0001, 4'b0000, {32'h0, 32'h0, 32'h0, LB}, "R2");
    issue(4'b0000, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LC}, "R2");
    // R4: repeat miss suppressed
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LA}, "R4");
    // R3: same line, different offset, on slot 3
    issue(4'b1000, 4'b0000, 4'b0000, {LA + 32'h3F, 32'h0, 32'h0, 32'h0}, "R3");
    // R6: prefetched hit on outstanding line
    issue(4'b0010, 4'b0010, 4'b0010, {32'h0, 32'h0, LA + 32'h8, 32'h0}, "R6");
    // R5: prefetched hit probes only, then a miss still triggers
    issue(4'b0001, 4'b0001, 4'b0001, {32'h0, 32'h0, 32'h0, LB}, "R5");
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LB}, "R5");
    idle(LAT + 1);
    // R9: slot 0 allocates, slot 1 pf-hit and slot 2 miss to same line suppressed
    issue(4'b0111, 4'b0010, 4'b0010, {32'h0, LC + 32'h4, LC + 32'h10, LC}, "R9");
    idle(LAT + 1);
    // R7: retirement edge
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LD}, "R7");
    idle(LAT - 2);
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LD}, "R7");
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LD}, "R7");
    idle(LAT + 1);
    // R8: fill the table in one cycle, then untracked misses
    issue(4'b1111, 4'b0000, 4'b0000,
          {32'h0010_0000, 32'h0011_0000, 32'h0012_0000, 32'h0013_0000}, "R8");
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, LE}, "R8");
    issue(4'b0100, 4'b0000, 4'b0000, {32'h0, LE, 32'h0, 32'h0}, "R8");
    issue(4'b0001, 4'b0000, 4'b0000, {32'h0, 32'h0, 32'h0, 32'h0012_0000}, "R8");
    idle(2);
    repeat (2) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule